// File: doc/BRIEF.md
# Three-Cell Pack Protection Sequencer

This block decides when the charge and discharge switches of a three-cell series pack may conduct. It does not measure anything itself. Outside comparators deliver, already synchronised to the clock, four level flags per cell. The flags say whether the cell is over the overcharge trip level, over the overcharge release level, under the overdischarge trip level, and at or over the overdischarge release level. Further single-bit flags report discharge current seen through the charge switch, a connected charger, an already qualified overcurrent trip, a pack control line and an overdischarge-detection inhibit.

Overcharge and overdischarge are each qualified by a delay counted in clock ticks. The two tick counts arrive on ports, so firmware or fuses can set them. Each cell keeps its own overcharge latch and its own conditioning (bleed) output. Overdischarge uses one shared latch with a power-down phase. The two latches are independent, so both may be set at once. A parameter picks the sense of the control line. All outputs are registered.

Top module: `batt_guard_ctrl`

## Requirements
- R1: While reset is held, chg_en, dsg_en, cond_out and pwr_down are all 0. On the first clock edge after release, with quiet inputs, both enables go to 1.
- R2: A cell whose ovc_det_hi bit is 1 on ovc_delay consecutive rising edges drives chg_en to 0 from that edge on. dsg_en does not change. A delay value of 0 behaves as 1.
- R3: If the trip flag drops before the delay expires, the delay counter restarts from zero. A pulse shorter than the delay changes no output.
- R4: An overcharge latch clears on the first edge where the cell's ovc_rel_hi bit is 0. chg_en returns to 1 once no cell latch remains, unless gated by R11 or R13.
- R5: A 1 on dsg_seen clears every overcharge latch on that edge, including latches of cells still above their release level.
- R6: cond_out[i] becomes 1 on the edge where cell i's own overcharge delay expires. It stays 1 for as long as ovc_rel_hi[i] is 1, whatever R5 or R10 do to the latch.
- R7: Any ovd_det_lo bit at 1 for ovd_delay consecutive edges drives dsg_en to 0 and pwr_down to 1 on that edge. chg_en does not change.
- R8: pwr_down stays 1 until an edge samples chg_seen = 1, and drops on that edge.
- R9: After power-down is left, dsg_en returns to 1 only on an edge where every ovd_rel_ok bit is 1.
- R10: A 1-to-0 change of chg_seen clears all overcharge latches. The overdischarge latch is kept.
- R11: With CTL_REVERSE = 0, ctl_in = 1 forces both enables to 0 one edge later. A pad left open must be pulled high. With CTL_REVERSE = 1, ctl_in = 0 does the same. When the inhibit ends, the enables follow the latch state again one edge later.
- R12: While ovd_inhibit is 1, no overdischarge detection occurs and the overdischarge delay counter does not advance.
- R13: ocur_trip = 1 forces both enables to 0 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovc_delay | input | CNT_W | Overcharge qualification, in ticks |
| ovd_delay | input | CNT_W | Overdischarge qualification, in ticks |
| ovc_det_hi | input | NCELL | Cell above overcharge trip level |
| ovc_rel_hi | input | NCELL | Cell above overcharge release level |
| ovd_det_lo | input | NCELL | Cell below overdischarge trip level |
| ovd_rel_ok | input | NCELL | Cell at or above overdischarge release level |
| dsg_seen | input | 1 | Discharge current detected |
| chg_seen | input | 1 | Charger detected |
| ocur_trip | input | 1 | Qualified overcurrent trip |
| ctl_in | input | 1 | Pack control line, sense set by CTL_REVERSE |
| ovd_inhibit | input | 1 | Suppress overdischarge detection |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| cond_out | output | NCELL | Per-cell conditioning drive |
| pwr_down | output | 1 | Power-down state flag |

## Verification
Every output is a flop. A gating input (control line, overcurrent) therefore shows its effect exactly one rising edge after it is first sampled. A delayed detection shows its effect on the edge that samples the trip flag for the N-th consecutive time. Releases land on the edge that samples the releasing flag.

The bench changes inputs on falling edges. A behavioural model is updated on each rising edge, and the model is compared with both instances, normal and reversed sense, on the next falling edge. Targeted checks sample one edge before and exactly on each expected transition, so an off-by-one delay count is caught.

// File: rtl/batt_guard_pkg.sv
package batt_guard_pkg;

   // overdischarge sequencing: detect -> power-down -> wait for release
   typedef enum logic [1:0] {
      OD_CLEAR = 2'd0,
      OD_PWRDN = 2'd1,
      OD_WAIT  = 2'd2
   } odis_state_e;

   localparam int unsigned DEF_CELLS = 3;
   localparam int unsigned DEF_CNT_W = 20;

endpackage

// File: rtl/guard_delay_timer.sv
module guard_delay_timer #(
   parameter int unsigned CNT_W = batt_guard_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W:0]   ONE_EXT = (CNT_W+1)'(1);

   logic [CNT_W-1:0] cnt_q;

   if (CNT_W < 2) begin : g_bad_width
      $error("guard_delay_timer: CNT_W must be at least 2");
   end

   // cnt_q holds the number of earlier consecutive edges with run high
   assign expire = run && (({1'b0, cnt_q} + ONE_EXT) >= {1'b0, limit});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/guard_ovc_cell.sv
module guard_ovc_cell #(
   parameter int unsigned CNT_W = batt_guard_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             det_hi,
   input  logic             rel_hi,
   input  logic             dsg_seen,
   input  logic             chg_gone,
   input  logic [CNT_W-1:0] limit,
   output logic             latch_q,
   output logic             latch_nxt,
   output logic             cond_q
);
   logic run;
   logic expire;
   logic clr;
   logic cond_nxt;

   // counting stops once latched so a release re-arms a full delay
   assign run = det_hi & ~latch_q;

   guard_delay_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .limit  (limit),
      .expire (expire)
   );

   assign clr       = ~rel_hi | dsg_seen | chg_gone;
   assign latch_nxt = expire | (latch_q & ~clr);
   assign cond_nxt  = expire | (cond_q & rel_hi);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= 1'b0;
         cond_q  <= 1'b0;
      end else begin
         latch_q <= latch_nxt;
         cond_q  <= cond_nxt;
      end
   end

   AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_q && rel_hi) |=> cond_q); // R6
   AST_REL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && !rel_hi) |=> !latch_q); // R4
   AST_DSG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && dsg_seen) |=> !latch_q); // R5

endmodule

// File: rtl/guard_odis_fsm.sv
module guard_odis_fsm
   import batt_guard_pkg::*;
#(
   parameter int unsigned NCELL = DEF_CELLS,
   parameter int unsigned CNT_W = DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCELL-1:0] det_lo,
   input  logic [NCELL-1:0] rel_ok,
   input  logic             inhibit,
   input  logic             chg_seen,
   input  logic [CNT_W-1:0] limit,
   output logic             pwr_down,
   output logic             clear_nxt
);
   odis_state_e st_q, st_d;
   logic run;
   logic expire;

   assign run = (|det_lo) & ~inhibit & (st_q == OD_CLEAR);

   guard_delay_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .limit  (limit),
      .expire (expire)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         OD_CLEAR: if (expire)    st_d = OD_PWRDN;
         OD_PWRDN: if (chg_seen)  st_d = OD_WAIT;
         OD_WAIT:  if (&rel_ok)   st_d = OD_CLEAR;
         default:                 st_d = OD_CLEAR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= OD_CLEAR;
      else        st_q <= st_d;
   end

   assign pwr_down  = (st_q == OD_PWRDN);
   assign clear_nxt = (st_d == OD_CLEAR);

   AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OD_PWRDN && !chg_seen) |=> (st_q == OD_PWRDN)); // R8
   AST_NO_DETECT_INH: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OD_CLEAR && inhibit) |=> (st_q != OD_PWRDN)); // R12
   AST_REL_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != OD_CLEAR && !(&rel_ok)) |=> (st_q != OD_CLEAR)); // R9

endmodule

// File: rtl/batt_guard_ctrl.sv
module batt_guard_ctrl
   import batt_guard_pkg::*;
#(
   parameter int unsigned NCELL       = DEF_CELLS,
   parameter int unsigned CNT_W       = DEF_CNT_W,
   parameter bit          CTL_REVERSE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] ovc_delay,
   input  logic [CNT_W-1:0] ovd_delay,
   input  logic [NCELL-1:0] ovc_det_hi,
   input  logic [NCELL-1:0] ovc_rel_hi,
   input  logic [NCELL-1:0] ovd_det_lo,
   input  logic [NCELL-1:0] ovd_rel_ok,
   input  logic             dsg_seen,
   input  logic             chg_seen,
   input  logic             ocur_trip,
   input  logic             ctl_in,
   input  logic             ovd_inhibit,
   output logic             chg_en,
   output logic             dsg_en,
   output logic [NCELL-1:0] cond_out,
   output logic             pwr_down
);
   logic             inh;
   logic             chg_prev_q;
   logic             chg_gone;
   logic [NCELL-1:0] ovc_latch;
   logic [NCELL-1:0] ovc_latch_nxt;
   logic             ovd_clear_nxt;

   if (NCELL < 1) begin : g_bad_cells
      $error("batt_guard_ctrl: NCELL must be at least 1");
   end

   // control-line sense
   if (CTL_REVERSE) begin : g_ctl_rev
      assign inh = ~ctl_in;
   end else begin : g_ctl_norm
      assign inh = ctl_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) chg_prev_q <= 1'b0;
      else        chg_prev_q <= chg_seen;
   end
   assign chg_gone = chg_prev_q & ~chg_seen;

   for (genvar c = 0; c < NCELL; c++) begin : g_cell
      guard_ovc_cell #(.CNT_W(CNT_W)) u_ovc (
         .clk       (clk),
         .rst_n     (rst_n),
         .det_hi    (ovc_det_hi[c]),
         .rel_hi    (ovc_rel_hi[c]),
         .dsg_seen  (dsg_seen),
         .chg_gone  (chg_gone),
         .limit     (ovc_delay),
         .latch_q   (ovc_latch[c]),
         .latch_nxt (ovc_latch_nxt[c]),
         .cond_q    (cond_out[c])
      );
   end

   guard_odis_fsm #(.NCELL(NCELL), .CNT_W(CNT_W)) u_odis (
      .clk       (clk),
      .rst_n     (rst_n),
      .det_lo    (ovd_det_lo),
      .rel_ok    (ovd_rel_ok),
      .inhibit   (ovd_inhibit),
      .chg_seen  (chg_seen),
      .limit     (ovd_delay),
      .pwr_down  (pwr_down),
      .clear_nxt (ovd_clear_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chg_en <= 1'b0;
         dsg_en <= 1'b0;
      end else begin
         chg_en <= ~inh & ~ocur_trip & ~(|ovc_latch_nxt);
         dsg_en <= ~inh & ~ocur_trip & ovd_clear_nxt;
      end
   end

   AST_OCUR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ocur_trip |=> (!chg_en && !dsg_en)); // R13
   AST_INH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      inh |=> (!chg_en && !dsg_en)); // R11
   AST_UNPLUG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_gone && !ocur_trip && !inh && !(|ovc_det_hi)) |=> chg_en); // R10
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!chg_en && !dsg_en && !pwr_down)); // R1

endmodule

// File: tb/tb_batt_guard_ctrl.sv
module tb_batt_guard_ctrl;
   localparam int W = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] ovc_delay = W'(8);
   logic [W-1:0] ovd_delay = W'(5);
   logic [2:0] ovc_hi = '0, ovc_rel = '0, ovd_lo = '0, ovd_ok = 3'b111;
   logic dsg_seen = 0, chg_seen = 0, ocur = 0, ctl_n = 0, ctl_r = 1, ovd_inh = 0;
   logic chg_en, dsg_en, pd, r_chg, r_dsg, r_pd;
   logic [2:0] cond, r_cond;

   always #4 clk = ~clk;

   batt_guard_ctrl #(.NCELL(3), .CNT_W(W), .CTL_REVERSE(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .ovc_delay(ovc_delay), .ovd_delay(ovd_delay),
      .ovc_det_hi(ovc_hi), .ovc_rel_hi(ovc_rel), .ovd_det_lo(ovd_lo), .ovd_rel_ok(ovd_ok),
      .dsg_seen(dsg_seen), .chg_seen(chg_seen), .ocur_trip(ocur), .ctl_in(ctl_n),
      .ovd_inhibit(ovd_inh), .chg_en(chg_en), .dsg_en(dsg_en), .cond_out(cond), .pwr_down(pd));

   batt_guard_ctrl #(.NCELL(3), .CNT_W(W), .CTL_REVERSE(1'b1)) dut_rev (
      .clk(clk), .rst_n(rst_n), .ovc_delay(ovc_delay), .ovd_delay(ovd_delay),
      .ovc_det_hi(ovc_hi), .ovc_rel_hi(ovc_rel), .ovd_det_lo(ovd_lo), .ovd_rel_ok(ovd_ok),
      .dsg_seen(dsg_seen), .chg_seen(chg_seen), .ocur_trip(ocur), .ctl_in(ctl_r),
      .ovd_inhibit(ovd_inh), .chg_en(r_chg), .dsg_en(r_dsg), .cond_out(r_cond), .pwr_down(r_pd));

   int n_chk = 0, n_err = 0;
   string cur_req = "R1";
   bit done = 0, started = 0;

   // behavioural reference model
   int m_oc [3];
   bit [2:0] m_off, m_cond;
   int m_dc, m_st;
   bit m_prev, m_chg, m_dsg, m_rchg, m_rdsg, m_pd;

   always @(posedge clk) begin : model
      bit gone, any_nxt, e, run;
      int st_n;
      started = 1;
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) m_oc[i] = 0;
         m_off = '0; m_cond = '0; m_dc = 0; m_st = 0; m_prev = 0;
         m_chg = 0; m_dsg = 0; m_rchg = 0; m_rdsg = 0; m_pd = 0;
      end else begin
         gone = m_prev && !chg_seen;
         any_nxt = 0;
         for (int i = 0; i < 3; i++) begin
            run = ovc_hi[i] && !m_off[i];
            e = run && (m_oc[i] + 1 >= int'(ovc_delay));
            m_oc[i] = run ? m_oc[i] + 1 : 0;
            m_off[i] = e || (m_off[i] && ovc_rel[i] && !dsg_seen && !gone);
            m_cond[i] = e || (m_cond[i] && ovc_rel[i]);
            any_nxt = any_nxt | m_off[i];
         end
         run = (|ovd_lo) && !ovd_inh && (m_st == 0);
         e = run && (m_dc + 1 >= int'(ovd_delay));
         m_dc = run ? m_dc + 1 : 0;
         st_n = m_st;
         if (m_st == 0 && e) st_n = 1;
         else if (m_st == 1 && chg_seen) st_n = 2;
         else if (m_st == 2 && (&ovd_ok)) st_n = 0;
         m_st = st_n;
         m_pd = (st_n == 1);
         m_chg = !ctl_n && !ocur && !any_nxt;
         m_dsg = !ctl_n && !ocur && (st_n == 0);
         m_rchg = ctl_r && !ocur && !any_nxt;
         m_rdsg = ctl_r && !ocur && (st_n == 0);
         m_prev = chg_seen;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started && !done) begin
         chk(cur_req, "chg_en vs model", chg_en, m_chg);
         chk(cur_req, "dsg_en vs model", dsg_en, m_dsg);
         chk(cur_req, "cond_out vs model", cond, m_cond);
         chk(cur_req, "pwr_down vs model", pd, m_pd);
         chk(cur_req, "rev chg_en vs model", r_chg, m_rchg);
         chk(cur_req, "rev dsg_en vs model", r_dsg, m_rdsg);
         chk(cur_req, "rev cond_out vs model", r_cond, m_cond);
         chk(cur_req, "rev pwr_down vs model", r_pd, m_pd);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired before test end");
      finish_run();
   end

   initial begin
      // R1 reset state
      step(3);
      chk("R1", "chg_en in reset", chg_en, 0);
      chk("R1", "dsg_en in reset", dsg_en, 0);
      chk("R1", "pwr_down in reset", pd, 0);
      rst_n = 1; step(1);
      chk("R1", "chg_en after reset", chg_en, 1);
      chk("R1", "dsg_en after reset", dsg_en, 1);

      // R3 glitch shorter than the delay
      cur_req = "R3";
      ovc_hi[0] = 1; ovc_rel[0] = 1; step(7);
      ovc_hi[0] = 0; step(1);
      ovc_hi[0] = 1; step(7);
      chk("R3", "chg_en after broken pulses", chg_en, 1);
      ovc_hi[0] = 0; ovc_rel[0] = 0; step(1);

      // R2 overcharge on cell 1
      cur_req = "R2";
      ovc_hi[1] = 1; ovc_rel[1] = 1; step(7);
      chk("R2", "chg_en one edge early", chg_en, 1);
      step(1);
      chk("R2", "chg_en at expiry", chg_en, 0);
      chk("R2", "dsg_en untouched", dsg_en, 1);
      chk("R6", "cond_out set for cell 1", cond, 3'b010);

      // R4 release by level
      cur_req = "R4";
      ovc_hi[1] = 0; step(2);
      chk("R4", "chg_en held above release", chg_en, 0);
      ovc_rel[1] = 0; step(1);
      chk("R4", "chg_en after release", chg_en, 1);
      chk("R6", "cond_out cleared", cond, 3'b000);

      // R5 release by discharge current, R6 conditioning kept
      cur_req = "R5";
      ovc_hi[2] = 1; ovc_rel[2] = 1; step(8);
      chk("R5", "chg_en latched", chg_en, 0);
      ovc_hi[2] = 0; dsg_seen = 1; step(1);
      dsg_seen = 0;
      chk("R5", "chg_en after discharge seen", chg_en, 1);
      chk("R6", "cond_out kept above release", cond, 3'b100);
      ovc_rel[2] = 0; step(1);
      chk("R6", "cond_out cleared at release", cond, 3'b000);

      // R7 overdischarge, R8 power-down hold, R9 release
      cur_req = "R7";
      ovd_lo[0] = 1; ovd_ok = 3'b110; step(4);
      chk("R7", "pwr_down one edge early", pd, 0);
      step(1);
      chk("R7", "pwr_down at expiry", pd, 1);
      chk("R7", "dsg_en at expiry", dsg_en, 0);
      chk("R7", "chg_en untouched", chg_en, 1);
      cur_req = "R8";
      ovd_lo[0] = 0; step(3);
      chk("R8", "pwr_down held without charger", pd, 1);
      chg_seen = 1; step(1);
      chk("R8", "pwr_down left on charger", pd, 0);
      cur_req = "R9";
      step(2);
      chk("R9", "dsg_en waits for release", dsg_en, 0);
      ovd_ok = 3'b111; step(1);
      chk("R9", "dsg_en after all released", dsg_en, 1);

      // R10 both latched, then charger removed
      cur_req = "R10";
      ovc_hi[0] = 1; ovc_rel[0] = 1; ovd_lo[1] = 1; ovd_ok = 3'b101; step(8);
      chk("R10", "chg_en with both latched", chg_en, 0);
      chk("R10", "dsg_en with both latched", dsg_en, 0);
      ovc_hi[0] = 0; ovd_lo[1] = 0; step(1);
      chg_seen = 0; step(1);
      chk("R10", "chg_en after unplug", chg_en, 1);
      chk("R10", "dsg_en kept after unplug", dsg_en, 0);
      chk("R6", "cond_out kept after unplug", cond, 3'b001);
      ovc_rel[0] = 0; ovd_ok = 3'b111; step(1);
      chk("R9", "dsg_en restored", dsg_en, 1);

      // R11 control line, both senses
      cur_req = "R11";
      ctl_n = 1; ctl_r = 0; step(1);
      chk("R11", "normal chg_en inhibited", chg_en, 0);
      chk("R11", "normal dsg_en inhibited", dsg_en, 0);
      chk("R11", "reverse chg_en inhibited", r_chg, 0);
      chk("R11", "reverse dsg_en inhibited", r_dsg, 0);
      ctl_n = 0; step(1);
      chk("R11", "normal chg_en restored", chg_en, 1);
      chk("R11", "reverse still inhibited", r_dsg, 0);
      ctl_r = 1; step(1);
      chk("R11", "reverse dsg_en restored", r_dsg, 1);

      // R12 overdischarge inhibit
      cur_req = "R12";
      ovd_inh = 1; ovd_lo[2] = 1; step(10);
      chk("R12", "pwr_down suppressed", pd, 0);
      chk("R12", "dsg_en kept", dsg_en, 1);
      ovd_lo[2] = 0; ovd_inh = 0; step(1);

      // R13 overcurrent
      cur_req = "R13";
      ocur = 1; step(1);
      chk("R13", "chg_en off", chg_en, 0);
      chk("R13", "dsg_en off", dsg_en, 0);
      ocur = 0; step(1);
      chk("R13", "dsg_en back", dsg_en, 1);

      // R2 minimum delay of one tick on the overdischarge side (R7)
      cur_req = "R7";
      ovd_delay = W'(1); ovd_lo[0] = 1; ovd_ok = 3'b110; step(1);
      chk("R7", "pwr_down with one-tick delay", pd, 1);
      ovd_lo[0] = 0; chg_seen = 1; step(1);
      ovd_ok = 3'b111; step(1);
      chk("R9", "dsg_en after one-tick cycle", dsg_en, 1);
      chg_seen = 0; step(2);

      finish_run();
   end
endmodule